// File: doc/BRIEF.md
# Move-Slot Immediate Decoder with Read-Only Constant Store

This block sits in the decode stage of a processor whose instruction word holds several parallel move slots, one per transport bus. It works out which buses take an immediate as their source value for the instruction and what that value is. There are two ways to encode a constant. In normal mode, each slot can carry a short signed constant of a few bits, which is widened to 32 bits for its own bus. In long-constant mode, a fixed, contiguous group of slots is given up to carry the bits of one 32-bit constant.

A long constant is not driven onto a bus directly. It is written into a small constant store. The buses can only read that store, and a later move reads it by giving an entry index in its source field, as it would for a register-file read port. The buses whose slots hold long-constant bits carry no ordinary transport in that instruction, and the block flags each of them with a per-bus squash output. All outputs are registered, so they describe the instruction that was presented on the previous clock edge.

Top module: `imd_top`

## Requirements
- R1: After synchronous reset, every bus_imm_vld and bus_squash bit is 0, bus_val is 0, and every constant-store entry reads back as 0.
- R2: In normal mode (instruction MSB = 0), a slot whose top two bits are 01 drives its bus with its low SIMM_W bits sign-extended to 32 bits and sets that bus's bus_imm_vld. This happens on the clock edge that samples the instruction.
- R3: A slot whose top two bits are 10 reads the constant-store entry named by its low IDX_W bits. It drives that entry onto its bus and sets bus_imm_vld.
- R4: A slot whose top two bits are 00 or 11 is not an immediate source. Its bus_imm_vld is 0 and its bus_val is 0.
- R5: In long-constant mode (instruction MSB = 1), exactly the buses LIMM_BUS0 to LIMM_BUS0+LIMM_SLOTS-1 (buses 2 and 3 by default) have bus_squash set and bus_imm_vld clear. In normal mode no bus is squashed.
- R6: A long-constant instruction writes the concatenation of its consumed slots into the constant store. The higher-numbered bus supplies the upper bits, so by default the value is {slot3, slot2}. The target entry is given by the IDX_W bits just below the instruction MSB.
- R7: A store read in the same instruction as a long-constant write returns the old entry value. A read in the next instruction returns the new value.
- R8: In long-constant mode, the buses whose slots are not consumed decode their slots exactly as in normal mode.
- R9: While instr_vld is 0, the next outputs show no immediate and no squash, and the constant store is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 1+IDX_W+NUM_BUS*SLOT_W | {mode bit, store index, slot NUM_BUS-1 .. slot 0} |
| bus_val | output | NUM_BUS*32 | Per-bus immediate value, bus b at bits [b*32 +: 32] |
| bus_imm_vld | output | NUM_BUS | Bus carries an immediate source value |
| bus_squash | output | NUM_BUS | Bus slot holds long-constant bits; no transport |

## Verification
The main decode is driven with randomly mixed slot kinds, modes and valid gaps. Random mixing catches a bus that takes its kind or mode from the wrong field. Directed short constants at both sign extremes (-32 and +31) tell correct sign extension apart from zero extension or a wrong field width. Back-to-back pairs of a long-constant write and a read of the same entry, within one instruction and then across two, separate a store that updates too early from one that updates too late. A long-constant word presented with instr_vld low and then read back shows that a dropped instruction does not leak into the store.

// File: rtl/imd_pkg.sv
package imd_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SRC_PLAIN = 2'b00,
    SRC_SIMM  = 2'b01,
    SRC_STORE = 2'b10,
    SRC_RSVD  = 2'b11
  } src_kind_e;
endpackage

// File: rtl/imd_slot_dec.sv
module imd_slot_dec #(
  parameter int SLOT_W = 16,
  parameter int SIMM_W = 6,
  parameter int IDX_W  = 1
) (
  input  logic [SLOT_W-1:0]          slot_i,
  output logic                       is_simm_o,
  output logic                       is_store_o,
  output logic [imd_pkg::DATA_W-1:0] simm_o,
  output logic [IDX_W-1:0]           idx_o
);
  imd_pkg::src_kind_e kind;
  logic               unused_slot_bits;

  assign kind       = imd_pkg::src_kind_e'(slot_i[SLOT_W-1 -: 2]);
  assign is_simm_o  = (kind == imd_pkg::SRC_SIMM);
  assign is_store_o = (kind == imd_pkg::SRC_STORE);
  assign simm_o     = {{(imd_pkg::DATA_W-SIMM_W){slot_i[SIMM_W-1]}}, slot_i[SIMM_W-1:0]};
  assign idx_o      = slot_i[IDX_W-1:0];
  assign unused_slot_bits = ^slot_i;
endmodule

// File: rtl/imd_limm_pack.sv
module imd_limm_pack #(
  parameter int NUM_BUS    = 4,
  parameter int SLOT_W     = 16,
  parameter int LIMM_BUS0  = 2,
  parameter int LIMM_SLOTS = 2
) (
  input  logic [NUM_BUS*SLOT_W-1:0]  slots_i,
  output logic [imd_pkg::DATA_W-1:0] limm_o
);
  localparam int RAW_W = LIMM_SLOTS * SLOT_W;

  logic [RAW_W-1:0] raw;

  // Consumed slots are contiguous: the higher bus supplies the upper bits.
  assign raw    = slots_i[LIMM_BUS0*SLOT_W +: RAW_W];
  assign limm_o = raw[imd_pkg::DATA_W-1:0];
endmodule

// File: rtl/imd_imm_unit.sv
module imd_imm_unit #(
  parameter int ENTRIES  = 2,
  parameter int IDX_W    = 1,
  parameter int RD_PORTS = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic [imd_pkg::DATA_W-1:0]          wr_data,
  input  logic [RD_PORTS*IDX_W-1:0]           rd_idx,
  output logic [RD_PORTS*imd_pkg::DATA_W-1:0] rd_data
);
  localparam int DW = imd_pkg::DATA_W;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else if (wr_en && (int'(wr_idx) < ENTRIES)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // Read ports see the value held before this edge's write.
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx = rd_idx[p*IDX_W +: IDX_W];
    assign rd_data[p*DW +: DW] = (int'(idx) < ENTRIES) ? mem[idx] : '0;
  end
endmodule

// File: rtl/imd_top.sv
module imd_top #(
  parameter int NUM_BUS    = 4,
  parameter int SLOT_W     = 16,
  parameter int SIMM_W     = 6,
  parameter int IU_ENTRIES = 2,
  parameter int LIMM_BUS0  = 2,
  localparam int IDX_W      = (IU_ENTRIES > 1) ? $clog2(IU_ENTRIES) : 1,
  localparam int LIMM_SLOTS = (imd_pkg::DATA_W + SLOT_W - 1) / SLOT_W,
  localparam int INSTR_W    = 1 + IDX_W + NUM_BUS * SLOT_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               instr_vld,
  input  logic [INSTR_W-1:0]                 instr,
  output logic [NUM_BUS*imd_pkg::DATA_W-1:0] bus_val,
  output logic [NUM_BUS-1:0]                 bus_imm_vld,
  output logic [NUM_BUS-1:0]                 bus_squash
);
  localparam int DW = imd_pkg::DATA_W;

  logic                      long_mode;
  logic [IDX_W-1:0]          wr_idx;
  logic [NUM_BUS*SLOT_W-1:0] slots;
  logic                      iu_we;
  logic [DW-1:0]             limm;
  logic [NUM_BUS*IDX_W-1:0]  rd_idx;
  logic [NUM_BUS*DW-1:0]     rd_data;
  logic [NUM_BUS-1:0]        is_simm, is_store, sq_d, vld_d;
  logic [DW-1:0]             simm_v [NUM_BUS];
  logic [DW-1:0]             val_d  [NUM_BUS];

  assign long_mode = instr[INSTR_W-1];
  assign wr_idx    = instr[INSTR_W-2 -: IDX_W];
  assign slots     = instr[NUM_BUS*SLOT_W-1:0];
  assign iu_we     = instr_vld & long_mode;

  imd_limm_pack #(
    .NUM_BUS(NUM_BUS), .SLOT_W(SLOT_W),
    .LIMM_BUS0(LIMM_BUS0), .LIMM_SLOTS(LIMM_SLOTS)
  ) i_pack (
    .slots_i(slots),
    .limm_o (limm)
  );

  imd_imm_unit #(
    .ENTRIES(IU_ENTRIES), .IDX_W(IDX_W), .RD_PORTS(NUM_BUS)
  ) i_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (iu_we),
    .wr_idx (wr_idx),
    .wr_data(limm),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    localparam bit IN_LIMM = (b >= LIMM_BUS0) && (b < LIMM_BUS0 + LIMM_SLOTS);

    logic sel_simm, sel_store;

    imd_slot_dec #(
      .SLOT_W(SLOT_W), .SIMM_W(SIMM_W), .IDX_W(IDX_W)
    ) i_dec (
      .slot_i    (slots[b*SLOT_W +: SLOT_W]),
      .is_simm_o (is_simm[b]),
      .is_store_o(is_store[b]),
      .simm_o    (simm_v[b]),
      .idx_o     (rd_idx[b*IDX_W +: IDX_W])
    );

    assign sq_d[b]   = iu_we & IN_LIMM;
    assign sel_simm  = instr_vld & ~sq_d[b] & is_simm[b];
    assign sel_store = instr_vld & ~sq_d[b] & is_store[b];
    assign vld_d[b]  = sel_simm | sel_store;
    assign val_d[b]  = sel_simm  ? simm_v[b] :
                       sel_store ? rd_data[b*DW +: DW] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_val     <= '0;
      bus_imm_vld <= '0;
      bus_squash  <= '0;
    end else begin
      for (int b = 0; b < NUM_BUS; b++) bus_val[b*DW +: DW] <= val_d[b];
      bus_imm_vld <= vld_d;
      bus_squash  <= sq_d;
    end
  end
endmodule

// File: rtl/imd_check.sv
module imd_check #(
  parameter int NUM_BUS    = 4,
  parameter int SLOT_W     = 16,
  parameter int SIMM_W     = 6,
  parameter int LIMM_SLOTS = 2,
  parameter int INSTR_W    = 66
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     instr_vld,
  input logic [INSTR_W-1:0]       instr,
  input logic [NUM_BUS*32-1:0]    bus_val,
  input logic [NUM_BUS-1:0]       bus_imm_vld,
  input logic [NUM_BUS-1:0]       bus_squash
);
  logic [1:0] kind0;
  assign kind0 = instr[SLOT_W-1 -: 2];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (bus_imm_vld == '0 && bus_squash == '0)); // R1

  AST_SIMM_EXTEND: assert property (@(posedge clk) disable iff (rst)
    (instr_vld && !instr[INSTR_W-1] && kind0 == 2'b01) |=>
      (bus_imm_vld[0] && bus_val[31:0] ==
        {{(32-SIMM_W){$past(instr[SIMM_W-1])}}, $past(instr[SIMM_W-1:0])})); // R2

  AST_PLAIN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (instr_vld && (kind0 == 2'b00 || kind0 == 2'b11)) |=>
      (!bus_imm_vld[0] && bus_val[31:0] == '0)); // R4

  AST_SQUASH_COUNT: assert property (@(posedge clk) disable iff (rst)
    (instr_vld && instr[INSTR_W-1]) |=> ($countones(bus_squash) == LIMM_SLOTS)); // R5

  AST_NO_SQUASH_NORMAL: assert property (@(posedge clk) disable iff (rst)
    !(instr_vld && instr[INSTR_W-1]) |=> (bus_squash == '0)); // R5

  AST_SQUASH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_squash & bus_imm_vld) == '0); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instr_vld |=> (bus_imm_vld == '0 && bus_squash == '0)); // R9
endmodule

bind imd_top imd_check #(
  .NUM_BUS(NUM_BUS), .SLOT_W(SLOT_W), .SIMM_W(SIMM_W),
  .LIMM_SLOTS(LIMM_SLOTS), .INSTR_W(INSTR_W)
) i_check (
  .clk        (clk),
  .rst        (rst),
  .instr_vld  (instr_vld),
  .instr      (instr),
  .bus_val    (bus_val),
  .bus_imm_vld(bus_imm_vld),
  .bus_squash (bus_squash)
);

// File: tb/test_imd_top.sv
`timescale 1ns/1ps
module test_imd_top;
  localparam int NB = 4;
  localparam int IW = 66;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_vld = 1'b0;
  logic [IW-1:0] instr = '0;
  logic [NB*32-1:0] bus_val;
  logic [NB-1:0]    bus_imm_vld, bus_squash;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] store_m [2];
  logic [31:0] exp_val [NB];
  logic        exp_vld [NB];
  logic        exp_sq  [NB];
  string       exp_tag [NB];
  bit          pend = 0;

  always #2.5 clk = ~clk;

  imd_top i_imd_top (
    .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr(instr),
    .bus_val(bus_val), .bus_imm_vld(bus_imm_vld), .bus_squash(bus_squash)
  );

  function automatic logic [15:0] mk_slot(input logic [1:0] kind, input logic [13:0] body);
    return {kind, body};
  endfunction

  function automatic logic [IW-1:0] mk_ins(input logic tpl, input logic idx,
      input logic [15:0] s3, input logic [15:0] s2, input logic [15:0] s1, input logic [15:0] s0);
    return {tpl, idx, s3, s2, s1, s0};
  endfunction

  task automatic compare_pending();
    for (int b = 0; b < NB; b++) begin
      checks++;
      if (bus_val[b*32 +: 32] !== exp_val[b] || bus_imm_vld[b] !== exp_vld[b] ||
          bus_squash[b] !== exp_sq[b]) begin
        fails++;
        $display("FAIL %s bus%0d: actual val=%h vld=%b sq=%b expected val=%h vld=%b sq=%b",
                 exp_tag[b], b, bus_val[b*32 +: 32], bus_imm_vld[b], bus_squash[b],
                 exp_val[b], exp_vld[b], exp_sq[b]);
      end
    end
  endtask

  task automatic issue(input logic v, input logic [IW-1:0] ins, input string tag);
    @(negedge clk);
    if (pend) compare_pending();
    for (int b = 0; b < NB; b++) begin
      logic [15:0] s;
      logic        sq;
      s  = ins[b*16 +: 16];
      sq = v && ins[IW-1] && (b == 2 || b == 3);
      exp_sq[b]  = sq;
      exp_vld[b] = 1'b0;
      exp_val[b] = '0;
      if (v && !sq && s[15:14] == 2'b01) begin
        exp_vld[b] = 1'b1;
        exp_val[b] = {{26{s[5]}}, s[5:0]};
      end else if (v && !sq && s[15:14] == 2'b10) begin
        exp_vld[b] = 1'b1;
        exp_val[b] = store_m[s[0]];
      end
      if (tag != "")                exp_tag[b] = tag;
      else if (!v)                  exp_tag[b] = "R9";
      else if (sq)                  exp_tag[b] = "R5";
      else if (ins[IW-1])           exp_tag[b] = "R8";
      else if (s[15:14] == 2'b01)   exp_tag[b] = "R2";
      else if (s[15:14] == 2'b10)   exp_tag[b] = "R3";
      else                          exp_tag[b] = "R4";
    end
    if (v && ins[IW-1]) store_m[ins[IW-2]] = ins[63:32]; // R6 write after same-cycle reads (R7)
    instr_vld = v;
    instr     = ins;
    pend      = 1;
  endtask

  initial begin
    logic [95:0] r;
    logic [IW-1:0] rd_all0, rd_all1;
    store_m[0] = '0;
    store_m[1] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state of outputs
    for (int b = 0; b < NB; b++) begin
      checks++;
      if (bus_val[b*32 +: 32] !== '0 || bus_imm_vld[b] !== 1'b0 || bus_squash[b] !== 1'b0) begin
        fails++;
        $display("FAIL R1 bus%0d: actual val=%h vld=%b sq=%b expected 0/0/0",
                 b, bus_val[b*32 +: 32], bus_imm_vld[b], bus_squash[b]);
      end
    end
    rd_all0 = mk_ins(0, 0, mk_slot(2, 0), mk_slot(2, 0), mk_slot(2, 0), mk_slot(2, 0));
    rd_all1 = mk_ins(0, 0, mk_slot(2, 1), mk_slot(2, 1), mk_slot(2, 1), mk_slot(2, 1));
    issue(1, rd_all0, "R1");
    issue(1, rd_all1, "R1");
    // R2: sign extremes
    issue(1, mk_ins(0, 0, mk_slot(1, 14'h0020), mk_slot(1, 14'h001F),
                    mk_slot(1, 14'h3FE0), mk_slot(1, 14'h0020)), "R2");
    issue(1, mk_ins(0, 0, mk_slot(1, 14'h003F), mk_slot(1, 14'h0000),
                    mk_slot(1, 14'h2A1F), mk_slot(1, 14'h001F)), "R2");
    // R4: plain and reserved kinds
    issue(1, mk_ins(0, 1, mk_slot(0, 14'h3FFF), mk_slot(3, 14'h1234),
                    mk_slot(0, 14'h0001), mk_slot(3, 14'h3FFF)), "R4");
    // R6: long constant into entry 1, then read back on every bus
    issue(1, mk_ins(1, 1, 16'hDEAD, 16'hBEEF, mk_slot(0, 0), mk_slot(0, 0)), "R6");
    issue(1, rd_all1, "R6");
    // R7: same-instruction read sees old, next sees new
    issue(1, mk_ins(1, 0, 16'h1234, 16'h5678, mk_slot(2, 0), mk_slot(2, 0)), "R7");
    issue(1, rd_all0, "R7");
    // R8: free buses keep decoding in long mode
    issue(1, mk_ins(1, 0, 16'hFFFF, 16'h0001, mk_slot(1, 14'h0025), mk_slot(2, 1)), "R8");
    // R9: dropped long-constant word must not write
    issue(0, mk_ins(1, 1, 16'hAAAA, 16'h5555, mk_slot(1, 1), mk_slot(2, 1)), "R9");
    issue(1, rd_all1, "R9");
    issue(1, rd_all0, "R3");
    // Random mix
    for (int n = 0; n < 400; n++) begin
      r = {$urandom(), $urandom(), $urandom()};
      issue(($urandom() % 10) != 0, r[IW-1:0], "");
    end
    issue(0, '0, "R9");
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule